// File: doc/BRIEF.md
# Memory Pattern Test Engine

This block exercises a region of word-addressed memory through a simple request port. Software-side logic programs a base byte address, a region size given as a power-of-two count of 32-bit words, a pattern mode and a direction (fill or check), then pulses a start input. A fill pass writes every word of the region once. A check pass reads every word back, compares it with the pattern a fill would have written, and reports the byte address of the first word that differs.

Three patterns are offered. A fixed 32-bit value shows stuck or bridged data bits quickly. Writing each word with its own byte address shows aliasing in the address path. The scrambled mode draws data from a 32-bit LFSR and also visits the words in an LFSR-driven order. This catches faults that depend on the order of accesses, at the price of a syndrome that is harder to read. Both passes replay an identical sequence from a fixed starting state, so the check pass sees exactly what the fill pass produced.

Top module: `mte_engine`

## Requirements
- R1: After reset, `done` and `busy` are 0, `mem_valid` is 0 and `err_addr` is 32'hFFFF_FFFF.
- R2: A `start` pulse while idle samples all `cfg_*` inputs, and `busy` is 1 from the next cycle. A `start` pulse, or any change of `cfg_*`, while busy has no effect on the pass that is running.
- R3: `cfg_mode` values 0 and 3 (fixed mode) write `cfg_value` to every word at `cfg_base + 4*i`, with i from 0 to 2^`cfg_len_log2` - 1. Each word is written exactly once, and words are visited in ascending order.
- R4: `cfg_mode` 1 (address mode) writes each word with its own byte address, visiting words in ascending order.
- R5: `cfg_mode` 2 (scrambled mode) visits each word of the region exactly once. When the region has more than one word, the first access is word index 1 and the last access is word index 0. A one-word region accesses only index 0.
- R6: In scrambled mode, the k-th access (k from 0) carries L^k(S), where S = 32'h1D87_2B41 and L(s) = (s >> 1) XOR (s[0] ? 32'hA300_0000 : 0). A check pass restarts from S.
- R7: A check pass (`cfg_check` = 1) stops at the first word, in visit order, whose read data differs from the expected pattern. It sets `err_addr` to that word's byte address and issues no further reads. When no word differs, `err_addr` is 32'hFFFF_FFFF. It is also all ones after a fill pass.
- R8: When a pass ends, `busy` falls and `done` rises in the same cycle. `done` and `err_addr` then hold until the next accepted `start`.
- R9: A request (`mem_valid` = 1) keeps `mem_addr`, `mem_write` and `mem_wdata` stable until `mem_ready` is 1. Read data is taken from `mem_rdata` exactly one cycle after the read is accepted. Every address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Region base byte address (word aligned) |
| cfg_len_log2 | input | LW | Region size as log2 of word count, at most IDX_W |
| cfg_mode | input | 2 | 0/3 fixed, 1 address, 2 scrambled |
| cfg_check | input | 1 | 0 fill, 1 check |
| cfg_value | input | 32 | Word written in fixed mode |
| start | input | 1 | Start pulse, honoured only when idle |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Last pass finished |
| err_addr | output | 32 | First failing byte address or all ones |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after acceptance |

## Verification
The assertions check the port protocol on every cycle. They confirm that a stalled request holds its address, direction and data, that no request appears while idle, that addresses are aligned, that `done` rises only as a pass ends and then holds, and that `err_addr` never moves while idle. Only the bench scenarios can show the values themselves. These include the data written in each mode, that the scrambled order covers every word exactly once with index 1 first and index 0 last, the LFSR data sequence, the choice of the earliest of several corrupted words, the absence of reads after a mismatch, and the insensitivity to `start` during a pass.

// File: rtl/mte_pkg.sv
package mte_pkg;

  typedef enum logic [1:0] {
    PAT_FIXED  = 2'd0,
    PAT_ADDR   = 2'd1,
    PAT_SCRAM  = 2'd2,
    PAT_FIXED2 = 2'd3
  } pat_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } eng_state_e;

  localparam logic [31:0] DATA_SEED = 32'h1D87_2B41;
  localparam logic [31:0] DATA_POLY = 32'hA300_0000;

  // Feedback tap masks for maximal-length index LFSRs of width 2..16
  function automatic logic [15:0] idx_taps(input int unsigned n);
    case (n)
      2:       idx_taps = 16'h0003;
      3:       idx_taps = 16'h0006;
      4:       idx_taps = 16'h000C;
      5:       idx_taps = 16'h0014;
      6:       idx_taps = 16'h0030;
      7:       idx_taps = 16'h0060;
      8:       idx_taps = 16'h00B8;
      9:       idx_taps = 16'h0110;
      10:      idx_taps = 16'h0240;
      11:      idx_taps = 16'h0500;
      12:      idx_taps = 16'h0E08;
      13:      idx_taps = 16'h1C80;
      14:      idx_taps = 16'h3802;
      15:      idx_taps = 16'h6000;
      16:      idx_taps = 16'hD008;
      default: idx_taps = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/mte_index_seq.sv
module mte_index_seq #(
  parameter int IDX_W = 12,
  parameter int LW    = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             adv,
  input  logic             scram,
  input  logic [LW-1:0]    len_log2,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  import mte_pkg::*;

  logic [IDX_W-1:0] cnt_q, cnt_d, idx_q, idx_d;
  logic [IDX_W:0]   one_sh;
  logic [IDX_W-1:0] len_mask, taps, lfsr_nx;
  logic             seq_en;

  assign one_sh   = (IDX_W+1)'(1) << len_log2;
  assign len_mask = one_sh[IDX_W-1:0] - IDX_W'(1);
  assign taps     = IDX_W'(idx_taps(int'(len_log2)));
  assign lfsr_nx  = ({idx_q[IDX_W-2:0], ^(idx_q & taps)}) & len_mask;
  assign seq_en   = init | adv;

  always_comb begin
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (init) begin
      cnt_d = '0;
      idx_d = (scram && (len_log2 != '0)) ? IDX_W'(1) : '0;
    end else if (adv) begin
      cnt_d = cnt_q + IDX_W'(1);
      if (!scram)                                idx_d = idx_q + IDX_W'(1);
      else if ((cnt_q + IDX_W'(1)) == len_mask)  idx_d = '0;
      else                                       idx_d = lfsr_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (seq_en) begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign idx  = idx_q;
  assign last = (cnt_q == len_mask);
endmodule

// File: rtl/mte_data_gen.sv
module mte_data_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        adv,
  input  logic [1:0]  mode,
  input  logic [31:0] value,
  input  logic [31:0] addr,
  output logic [31:0] pattern
);
  import mte_pkg::*;

  logic [31:0] lfsr_q, lfsr_d;
  logic        lfsr_en;

  assign lfsr_en = init | adv;

  always_comb begin
    if (init) lfsr_d = DATA_SEED;
    else      lfsr_d = (lfsr_q >> 1) ^ (lfsr_q[0] ? DATA_POLY : 32'h0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lfsr_q <= DATA_SEED;
    else if (lfsr_en) lfsr_q <= lfsr_d;
  end

  always_comb begin
    case (pat_mode_e'(mode))
      PAT_ADDR:  pattern = addr;
      PAT_SCRAM: pattern = lfsr_q;
      default:   pattern = value;
    endcase
  end
endmodule

// File: rtl/mte_engine.sv
module mte_engine #(
  parameter int IDX_W = 12,
  parameter int LW    = $clog2(IDX_W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cfg_base,
  input  logic [LW-1:0] cfg_len_log2,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_check,
  input  logic [31:0]   cfg_value,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [31:0]   err_addr,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  import mte_pkg::*;

  eng_state_e       state_q, state_d;
  logic [31:0]      base_q, value_q, err_q, err_d;
  logic [LW-1:0]    len_q, len_eff, len_sel;
  logic [1:0]       mode_q, mode_sel;
  logic             check_q, done_q, done_d;
  logic             ld_cfg, seq_init, seq_adv, last;
  logic [IDX_W-1:0] idx;
  logic [31:0]      pattern;

  assign len_eff  = (cfg_len_log2 > LW'(IDX_W)) ? LW'(IDX_W) : cfg_len_log2;
  assign len_sel  = ld_cfg ? len_eff  : len_q;
  assign mode_sel = ld_cfg ? cfg_mode : mode_q;

  mte_index_seq #(.IDX_W(IDX_W), .LW(LW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (seq_init),
    .adv      (seq_adv),
    .scram    (mode_sel == PAT_SCRAM),
    .len_log2 (len_sel),
    .idx      (idx),
    .last     (last)
  );

  assign mem_addr = base_q + (32'(idx) << 2);

  mte_data_gen u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (seq_init),
    .adv     (seq_adv),
    .mode    (mode_q),
    .value   (value_q),
    .addr    (mem_addr),
    .pattern (pattern)
  );

  always_comb begin
    state_d   = state_q;
    done_d    = done_q;
    err_d     = err_q;
    ld_cfg    = 1'b0;
    seq_init  = 1'b0;
    seq_adv   = 1'b0;
    mem_valid = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        ld_cfg   = 1'b1;
        seq_init = 1'b1;
        done_d   = 1'b0;
        err_d    = '1;
        state_d  = ST_REQ;
      end
      ST_REQ: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          if (check_q) state_d = ST_RSP;
          else if (last) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else seq_adv = 1'b1;
        end
      end
      ST_RSP: begin
        if (mem_rdata != pattern) begin
          err_d   = mem_addr;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (last) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          seq_adv = 1'b1;
          state_d = ST_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= '1;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      value_q <= '0;
      len_q   <= '0;
      mode_q  <= '0;
      check_q <= 1'b0;
    end else if (ld_cfg) begin
      base_q  <= {cfg_base[31:2], 2'b00};
      value_q <= cfg_value;
      len_q   <= len_eff;
      mode_q  <= cfg_mode;
      check_q <= cfg_check;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err_addr  = err_q;
  assign mem_write = ~check_q;
  assign mem_wdata = pattern;
endmodule

// File: rtl/mte_chk.sv
module mte_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] err_addr,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));

  // R9
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !busy && !start |=> done);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(err_addr));

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind mte_engine mte_chk u_mte_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .err_addr  (err_addr),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/test_mte_engine.sv
module test_mte_engine;
  localparam int IDX_W = 12;
  localparam int LW    = $clog2(IDX_W + 1);

  logic          clk, rst_n;
  logic [31:0]   cfg_base, cfg_value, err_addr, mem_addr, mem_wdata, mem_rdata;
  logic [LW-1:0] cfg_len_log2;
  logic [1:0]    cfg_mode;
  logic          cfg_check, start, busy, done, mem_valid, mem_ready, mem_write;

  int checks, errors, hs_bad, rd_cnt;
  logic [31:0] mem [int unsigned];
  int unsigned wcnt [int unsigned];
  logic [31:0] wa_q [$];
  logic [31:0] wd_q [$];
  logic        hold_pend;
  logic [31:0] pa, pd;
  logic        pw;

  mte_engine #(.IDX_W(IDX_W)) i_mte_engine (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len_log2(cfg_len_log2),
    .cfg_mode(cfg_mode), .cfg_check(cfg_check), .cfg_value(cfg_value), .start(start),
    .busy(busy), .done(done), .err_addr(err_addr), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) mem_ready = (($urandom % 4) != 0);

  // memory model: write stores, read returns data on the following cycle
  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        mem[mem_addr] = mem_wdata;
        wcnt[mem_addr] = (wcnt.exists(mem_addr) ? wcnt[mem_addr] : 0) + 1;
        wa_q.push_back(mem_addr);
        wd_q.push_back(mem_wdata);
      end else begin
        rd_cnt++;
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'hDEAD_0000;
      end
    end
    if (rst_n && hold_pend && !(mem_valid && mem_addr == pa && mem_write == pw && mem_wdata == pd))
      hs_bad++;
    hold_pend <= rst_n && mem_valid && !mem_ready;
    pa <= mem_addr; pw <= mem_write; pd <= mem_wdata;
  end

  function automatic logic [31:0] lstep(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'hA300_0000 : 32'h0);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    mem.delete(); wcnt.delete(); wa_q.delete(); wd_q.delete();
  endtask

  task automatic run(input logic [31:0] b, input int l, input logic [1:0] m,
                     input bit c, input logic [31:0] v);
    @(negedge clk);
    cfg_base = b; cfg_len_log2 = LW'(l); cfg_mode = m; cfg_check = c; cfg_value = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
    while (!done) @(negedge clk);
  endtask

  task automatic check_fixed(input logic [31:0] b, input int l, input logic [31:0] v, input string req);
    int bad = 0;
    for (int i = 0; i < (1 << l); i++) begin
      logic [31:0] a = b + 32'(i) * 4;
      if (!mem.exists(a) || mem[a] !== v || wcnt[a] != 1) bad++;
    end
    chk(bad == 0 && wa_q.size() == (1 << l), req, 32'(bad), 32'd0);
  endtask

  task automatic check_scram(input logic [31:0] b, input int l);
    int bad = 0, dbad = 0;
    logic [31:0] s = 32'h1D87_2B41;
    for (int i = 0; i < (1 << l); i++)
      if (!wcnt.exists(b + 32'(i) * 4) || wcnt[b + 32'(i) * 4] != 1) bad++;
    chk(bad == 0 && wa_q.size() == (1 << l), "R5 each word once", 32'(bad), 32'd0);
    chk(wa_q[0] == ((l == 0) ? b : b + 4), "R5 first index", wa_q[0], (l == 0) ? b : b + 4);
    chk(wa_q[wa_q.size()-1] == b, "R5 last index 0", wa_q[wa_q.size()-1], b);
    for (int k = 0; k < wd_q.size(); k++) begin
      if (wd_q[k] !== s) dbad++;
      s = lstep(s);
    end
    chk(dbad == 0, "R6 data sequence", 32'(dbad), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] b;
    int l, j;
    void'($urandom(32'd7));
    checks = 0; errors = 0; hs_bad = 0; rd_cnt = 0; hold_pend = 1'b0;
    start = 1'b0; cfg_base = '0; cfg_len_log2 = '0; cfg_mode = '0; cfg_check = 1'b0;
    cfg_value = '0; mem_rdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(!done && !busy && !mem_valid, "R1 reset flags", {29'd0, done, busy, mem_valid}, 32'd0);
    chk(err_addr == 32'hFFFF_FFFF, "R1 reset err_addr", err_addr, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 fixed fill and check
    clear_mem();
    run(32'h0000_1000, 4, 2'd0, 1'b0, 32'hA5A5_5A5A);
    check_fixed(32'h0000_1000, 4, 32'hA5A5_5A5A, "R3 fixed fill");
    chk(err_addr == 32'hFFFF_FFFF, "R7 fill leaves all ones", err_addr, 32'hFFFF_FFFF);
    chk(done && !busy, "R8 done after pass", {30'd0, done, busy}, 32'd2);
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R8 done holds", 32'(done), 32'd1);
    run(32'h0000_1000, 4, 2'd0, 1'b1, 32'hA5A5_5A5A);
    chk(err_addr == 32'hFFFF_FFFF, "R7 fixed check passes", err_addr, 32'hFFFF_FFFF);

    // R3 mode 3 also fixed
    clear_mem();
    run(32'h0002_0000, 2, 2'd3, 1'b0, 32'h0F0F_1234);
    check_fixed(32'h0002_0000, 2, 32'h0F0F_1234, "R3 mode 3 fixed");

    // R4 address mode, two corrupted words, earliest reported, R7 stops
    clear_mem();
    run(32'h0000_8000, 5, 2'd1, 1'b0, 32'h0);
    begin
      int bad = 0;
      for (int i = 0; i < 32; i++)
        if (mem[32'h8000 + 32'(i) * 4] !== 32'h8000 + 32'(i) * 4 || wa_q[i] != 32'h8000 + 32'(i) * 4) bad++;
      chk(bad == 0, "R4 address data ascending", 32'(bad), 32'd0);
    end
    run(32'h0000_8000, 5, 2'd1, 1'b1, 32'h0);
    chk(err_addr == 32'hFFFF_FFFF, "R4 address check passes", err_addr, 32'hFFFF_FFFF);
    mem[32'h8000 + 80] = 32'h0; mem[32'h8000 + 28] ^= 32'h0001_0000;
    rd_cnt = 0;
    run(32'h0000_8000, 5, 2'd1, 1'b1, 32'h0);
    chk(err_addr == 32'h0000_801C, "R7 earliest mismatch", err_addr, 32'h0000_801C);
    chk(rd_cnt == 8, "R7 no reads after mismatch", 32'(rd_cnt), 32'd8);

    // R5 R6 scrambled mode, random regions
    for (int it = 0; it < 8; it++) begin
      l = (it == 0) ? 0 : (it == 1) ? 1 : 2 + ($urandom % 7);
      b = $urandom & 32'hFFF0_0000;
      clear_mem();
      run(b, l, 2'd2, 1'b0, $urandom);
      check_scram(b, l);
      run(b, l, 2'd2, 1'b1, 32'h0);
      chk(err_addr == 32'hFFFF_FFFF, "R6 scrambled check passes", err_addr, 32'hFFFF_FFFF);
      j = $urandom % (1 << l);
      mem[b + 32'(j) * 4] ^= 32'h8000_0001;
      run(b, l, 2'd2, 1'b1, 32'h0);
      chk(err_addr == b + 32'(j) * 4, "R7 scrambled mismatch", err_addr, b + 32'(j) * 4);
    end

    // R2 start and cfg changes during a pass are ignored
    clear_mem();
    @(negedge clk);
    cfg_base = 32'h0004_0000; cfg_len_log2 = LW'(6); cfg_mode = 2'd0; cfg_check = 1'b0;
    cfg_value = 32'h3C3C_C3C3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    cfg_base = 32'h0005_0000; cfg_mode = 2'd1; cfg_check = 1'b1; cfg_value = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check_fixed(32'h0004_0000, 6, 32'h3C3C_C3C3, "R2 start ignored while busy");
    repeat (4) @(negedge clk);
    chk(!busy && mem_valid == 1'b0, "R2 no second pass", {30'd0, busy, mem_valid}, 32'd0);

    // R9 handshake stability observed across all runs
    chk(hs_bad == 0, "R9 request held until ready", 32'(hs_bad), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule